// File: doc/BRIEF.md
# Variable-Length Instruction Format Decoder

This block sits behind a byte-wide instruction fetch stream and turns each instruction into decoded fields. Every instruction begins with a 16-bit halfword, sent high byte first. The top two bits of that halfword pick one of three encoding forms, and each form has its own field layout:

- **Register form:** an 8-bit opcode and two 4-bit register fields.
- **Immediate form:** a 2-bit opcode, one register field and an 8-bit unsigned constant.
- **Branch form:** a 4-bit condition code and a 10-bit signed halfword displacement.

A fixed set of register-form opcodes is followed by a 32-bit word, sent most significant byte first. That word makes the instruction six bytes long instead of two.

A small control FSM tracks where the stream is: the first halfword byte, the second halfword byte, or the trailing word. It drives a datapath through a struct of strobes. The datapath holds the captured halfword and the trailing word. A combinational field decoder reads the held halfword and reports the form, the opcode, the register fields, the constant, the byte displacement, whether a trailing word follows, the total length and an illegal-opcode flag. A downstream execute stage uses the `decValid` and `immValid` pulses to pick up each result.

Top module: `vlen_insn_decoder`

## Requirements
- R1: Form codes on `form`: bit 15 = 0 gives 1 (register form); bits 15:14 = 10 give 2 (immediate form); bits 15:14 = 11 give 3 (branch form). `form` is never 0.
- R2: In register form, `opcode` = bits 15:8, `regA` = bits 7:4 and `regB` = bits 3:0. `imm8` and `disp` are 0.
- R3: In immediate form, `opcode` = bits 13:12 (zero-extended), `regA` = bits 11:8 and `imm8` = bits 7:0. `regB` and `disp` are 0. Opcodes 0 to 3 are add-constant, subtract-constant, read special register and write special register.
- R4: In branch form, `opcode` = bits 13:10 (zero-extended) and `disp` = bits 9:0 sign-extended and shifted left by one. Bit 0 of `disp` is therefore always 0.
- R5: Register-form opcodes 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30, 0x36, 0x37, 0x38 and 0x39 set `hasImm` and give `instLen` = 6. Every other instruction gives `hasImm` = 0 and `instLen` = 2.
- R6: `illegal` is set in three cases:
  - a register-form opcode outside 0x01–0x0F and 0x19–0x39 (this includes 0x00 and 0x10–0x18);
  - a branch condition code of 0xA–0xF;
  - never in immediate form.
  An illegal instruction has `hasImm` = 0.
- R7: The halfword is big-endian: the first accepted byte becomes bits 15:8. `decValid` is high for exactly one cycle, right after the clock edge that accepts the second byte. The decoded fields hold their values until the next instruction's second byte is accepted.
- R8: When `hasImm` is set, the next four accepted bytes form `immWord`, most significant byte first. `immValid` is high for one cycle right after the edge that accepts the fourth byte. The next accepted byte is the high byte of a new instruction.
- R9: A cycle with `byteValid` low changes neither the capture position nor any output, whatever the value on `byteData`.
- R10: After reset, `decValid` and `immValid` are low, `immWord` is 0, and the next accepted byte is taken as a halfword high byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | `byteData` carries a fetch byte this cycle |
| byteData | input | 8 | Fetch stream byte |
| decValid | output | 1 | One-cycle pulse: a new halfword has been decoded |
| form | output | 2 | Encoding form: 1, 2 or 3 |
| opcode | output | 8 | Opcode or condition code, zero-extended |
| regA | output | 4 | First register field |
| regB | output | 4 | Second register field (register form only) |
| imm8 | output | 8 | Unsigned 8-bit constant (immediate form only) |
| disp | output | DISP_W | Signed branch byte displacement (branch form only) |
| hasImm | output | 1 | A 32-bit trailing word follows |
| instLen | output | LEN_W | Instruction length in bytes (2 or 6) |
| illegal | output | 1 | Opcode has no defined meaning |
| immValid | output | 1 | One-cycle pulse: `immWord` is complete |
| immWord | output | IMM_BYTES*8 | Trailing word, assembled big-endian |

## Verification
The halfword register and the two pulse flags are loaded on the same edge. So the decoded fields and `decValid` both become visible right after the edge that accepts the second byte, and `immValid` and `immWord` right after the edge that accepts the fourth trailing byte. No further cycle of latency is added.

The bench drives bytes on falling edges. A monitor samples on each following falling edge. It pops an expected item off the scoreboard queue exactly when a pulse is seen, and it flags any pulse that arrives with nothing queued. Gaps with junk data on `byteData` are placed between bytes, so a pulse that comes early, late or twice shows up as a mismatch or as an unexpected pulse.

// File: rtl/vld_pkg.sv
package vld_pkg;

  localparam int BYTE_W   = 8;
  localparam int HALF_W   = 16;
  localparam int DFIELD_W = 10;

  typedef enum logic [1:0] {
    FORM_NONE  = 2'd0,
    FORM_REG   = 2'd1,
    FORM_IMM   = 2'd2,
    FORM_BRNCH = 2'd3
  } form_e;

  typedef struct packed {
    logic loadHi;
    logic loadLo;
    logic shiftImm;
    logic immDone;
  } strobe_t;

  // Register-form opcodes that are followed by a 32-bit word.
  function automatic logic regOpHasTail(input logic [7:0] op);
    case (op)
      8'h01, 8'h03, 8'h08, 8'h09, 8'h0C, 8'h0D,
      8'h1A, 8'h1B, 8'h1D, 8'h1F, 8'h20, 8'h22,
      8'h24, 8'h30, 8'h36, 8'h37, 8'h38, 8'h39: regOpHasTail = 1'b1;
      default:                                  regOpHasTail = 1'b0;
    endcase
  endfunction

  // Register-form opcodes with a defined meaning.
  function automatic logic regOpDefined(input logic [7:0] op);
    regOpDefined = ((op >= 8'h01) && (op <= 8'h0F)) ||
                   ((op >= 8'h19) && (op <= 8'h39));
  endfunction

endpackage

// File: rtl/vld_field_decode.sv
module vld_field_decode
  import vld_pkg::*;
#(
  parameter int DISP_W    = 32,
  parameter int IMM_BYTES = 4,
  parameter int LEN_W     = 3
) (
  input  logic [HALF_W-1:0] hw,
  output form_e             formOut,
  output logic [7:0]        opcode,
  output logic [3:0]        regA,
  output logic [3:0]        regB,
  output logic [7:0]        imm8,
  output logic [DISP_W-1:0] disp,
  output logic              hasTail,
  output logic [LEN_W-1:0]  instLen,
  output logic              illegal
);

  localparam int            EXT_W     = DISP_W - DFIELD_W - 1;
  localparam logic [3:0]    BR_MAX    = 4'd9;
  localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(2);
  localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(2 + IMM_BYTES);

  always_comb begin
    formOut = FORM_REG;
    opcode  = '0;
    regA    = '0;
    regB    = '0;
    imm8    = '0;
    disp    = '0;
    hasTail = 1'b0;
    illegal = 1'b0;
    if (!hw[15]) begin
      formOut = FORM_REG;
      opcode  = hw[15:8];
      regA    = hw[7:4];
      regB    = hw[3:0];
      hasTail = regOpHasTail(hw[15:8]);
      illegal = !regOpDefined(hw[15:8]);
    end else if (!hw[14]) begin
      formOut = FORM_IMM;
      opcode  = {6'd0, hw[13:12]};
      regA    = hw[11:8];
      imm8    = hw[7:0];
    end else begin
      formOut = FORM_BRNCH;
      opcode  = {4'd0, hw[13:10]};
      disp    = {{EXT_W{hw[DFIELD_W-1]}}, hw[DFIELD_W-1:0], 1'b0};
      illegal = (hw[13:10] > BR_MAX);
    end
    instLen = hasTail ? LEN_LONG : LEN_SHORT;
  end

endmodule

// File: rtl/vld_fetch_ctrl.sv
module vld_fetch_ctrl
  import vld_pkg::*;
#(
  parameter int IMM_BYTES = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    byteValid,
  input  logic    tailNeeded,
  output strobe_t strb
);

  localparam int CNT_W = (IMM_BYTES > 1) ? $clog2(IMM_BYTES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IMM_BYTES - 1);

  typedef enum logic [1:0] {ST_HI, ST_LO, ST_TAIL} state_e;

  state_e          state;
  logic [CNT_W-1:0] tailCnt;

  always_comb begin
    strb = '0;
    case (state)
      ST_HI:   strb.loadHi   = byteValid;
      ST_LO:   strb.loadLo   = byteValid;
      ST_TAIL: begin
        strb.shiftImm = byteValid;
        strb.immDone  = byteValid && (tailCnt == CNT_LAST);
      end
      default: strb = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_HI;
      tailCnt <= '0;
    end else if (byteValid) begin
      case (state)
        ST_HI: state <= ST_LO;
        ST_LO: begin
          state   <= tailNeeded ? ST_TAIL : ST_HI;
          tailCnt <= '0;
        end
        ST_TAIL: begin
          if (tailCnt == CNT_LAST) state <= ST_HI;
          tailCnt <= tailCnt + CNT_W'(1);
        end
        default: state <= ST_HI;
      endcase
    end
  end

endmodule

// File: rtl/vld_fetch_dp.sv
module vld_fetch_dp
  import vld_pkg::*;
#(
  parameter int IMM_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [BYTE_W-1:0]         byteData,
  input  strobe_t                   strb,
  output logic [HALF_W-1:0]         hwReg,
  output logic                      tailNeeded,
  output logic                      decValid,
  output logic                      immValid,
  output logic [IMM_BYTES*BYTE_W-1:0] immWord
);

  localparam int IMM_W = IMM_BYTES * BYTE_W;

  logic [BYTE_W-1:0] hiReg;

  // The opcode sits entirely in the high byte, so the tail decision
  // is known before the low byte arrives.
  assign tailNeeded = !hiReg[7] && regOpHasTail(hiReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiReg    <= '0;
      hwReg    <= '0;
      immWord  <= '0;
      decValid <= 1'b0;
      immValid <= 1'b0;
    end else begin
      if (strb.loadHi)   hiReg   <= byteData;
      if (strb.loadLo)   hwReg   <= {hiReg, byteData};
      if (strb.shiftImm) immWord <= {immWord[IMM_W-BYTE_W-1:0], byteData};
      decValid <= strb.loadLo;
      immValid <= strb.immDone;
    end
  end

endmodule

// File: rtl/vlen_insn_decoder.sv
module vlen_insn_decoder
  import vld_pkg::*;
#(
  parameter int DISP_W    = 32,
  parameter int IMM_BYTES = 4,
  parameter int LEN_W     = $clog2(IMM_BYTES + 3)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        byteValid,
  input  logic [7:0]                  byteData,
  output logic                        decValid,
  output logic [1:0]                  form,
  output logic [7:0]                  opcode,
  output logic [3:0]                  regA,
  output logic [3:0]                  regB,
  output logic [7:0]                  imm8,
  output logic [DISP_W-1:0]           disp,
  output logic                        hasImm,
  output logic [LEN_W-1:0]            instLen,
  output logic                        illegal,
  output logic                        immValid,
  output logic [IMM_BYTES*8-1:0]      immWord
);

  strobe_t           strb;
  logic              tailNeeded;
  logic [HALF_W-1:0] hwReg;
  form_e             formDec;

  vld_fetch_ctrl #(.IMM_BYTES(IMM_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid),
    .tailNeeded(tailNeeded), .strb(strb)
  );

  vld_fetch_dp #(.IMM_BYTES(IMM_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .byteData(byteData), .strb(strb),
    .hwReg(hwReg), .tailNeeded(tailNeeded), .decValid(decValid),
    .immValid(immValid), .immWord(immWord)
  );

  vld_field_decode #(.DISP_W(DISP_W), .IMM_BYTES(IMM_BYTES), .LEN_W(LEN_W)) u_dec (
    .hw(hwReg), .formOut(formDec), .opcode(opcode), .regA(regA),
    .regB(regB), .imm8(imm8), .disp(disp), .hasTail(hasImm),
    .instLen(instLen), .illegal(illegal)
  );

  assign form = formDec;

endmodule

// File: rtl/vld_checker.sv
module vld_checker #(
  parameter int DISP_W    = 32,
  parameter int IMM_BYTES = 4,
  parameter int LEN_W     = 3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   byteValid,
  input logic                   decValid,
  input logic [1:0]             form,
  input logic [7:0]             imm8,
  input logic [DISP_W-1:0]      disp,
  input logic                   hasImm,
  input logic [LEN_W-1:0]       instLen,
  input logic                   illegal,
  input logic                   immValid
);

  // R1
  form_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    form != 2'd0);

  // R3
  imm_form_no_disp_chk: assert property (@(posedge clk) disable iff (!rstN)
    form == 2'd2 |-> disp == '0);

  // R4
  disp_even_chk: assert property (@(posedge clk) disable iff (!rstN)
    form == 2'd3 |-> (disp[0] == 1'b0 && imm8 == 8'd0));

  // R5
  len_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    hasImm ? (instLen == LEN_W'(2 + IMM_BYTES)) : (instLen == LEN_W'(2)));

  // R6
  illegal_no_tail_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !hasImm);

  // R7
  dec_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    decValid |=> !decValid);

  // R8
  imm_after_tail_chk: assert property (@(posedge clk) disable iff (!rstN)
    immValid |-> (hasImm && !decValid));

  // R9
  dec_needs_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(decValid) |-> $past(byteValid));

endmodule

bind vlen_insn_decoder vld_checker #(
  .DISP_W(DISP_W), .IMM_BYTES(IMM_BYTES), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .decValid(decValid),
  .form(form), .imm8(imm8), .disp(disp), .hasImm(hasImm),
  .instLen(instLen), .illegal(illegal), .immValid(immValid)
);

// File: tb/vlen_insn_decoder_tb.sv
`timescale 1ns/1ps
module vlen_insn_decoder_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = 8'h00;
  logic        decValid, hasImm, illegal, immValid;
  logic [1:0]  form;
  logic [7:0]  opcode, imm8;
  logic [3:0]  regA, regB;
  logic [31:0] disp, immWord;
  logic [2:0]  instLen;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [15:0] hw;
    logic [1:0]  form;
    logic [7:0]  opcode;
    logic [3:0]  regA, regB;
    logic [7:0]  imm8;
    logic [31:0] disp;
    logic        tail;
    logic [2:0]  len;
    logic        ill;
  } exp_t;

  exp_t        decQ[$];
  logic [31:0] immQ[$];
  exp_t        lastExp;

  always #10 clk = ~clk;

  vlen_insn_decoder u_dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .decValid(decValid), .form(form), .opcode(opcode), .regA(regA),
    .regB(regB), .imm8(imm8), .disp(disp), .hasImm(hasImm),
    .instLen(instLen), .illegal(illegal), .immValid(immValid),
    .immWord(immWord)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [15:0] h);
    exp_t e;
    int   d;
    e = '{hw: h, form: 2'd1, opcode: 8'd0, regA: 4'd0, regB: 4'd0,
          imm8: 8'd0, disp: 32'd0, tail: 1'b0, len: 3'd2, ill: 1'b0};
    if (h[15] == 1'b0) begin
      e.opcode = h[15:8];
      e.regA   = h[7:4];
      e.regB   = h[3:0];
      e.tail   = h[15:8] inside {8'h01, 8'h03, 8'h08, 8'h09, 8'h0C, 8'h0D,
                 8'h1A, 8'h1B, 8'h1D, 8'h1F, 8'h20, 8'h22, 8'h24, 8'h30,
                 8'h36, 8'h37, 8'h38, 8'h39};
      e.ill    = !(h[15:8] inside {[8'h01:8'h0F], [8'h19:8'h39]});
    end else if (h[14] == 1'b0) begin
      e.form   = 2'd2;
      e.opcode = {6'd0, h[13:12]};
      e.regA   = h[11:8];
      e.imm8   = h[7:0];
    end else begin
      e.form   = 2'd3;
      e.opcode = {4'd0, h[13:10]};
      d = int'(h[9:0]);
      if (d >= 512) d = d - 1024;
      e.disp   = 32'(d * 2);
      e.ill    = h[13:10] > 4'd9;
    end
    e.len = e.tail ? 3'd6 : 3'd2;
    return e;
  endfunction

  task automatic putByte(input logic [7:0] b, input int gap);
    byteValid = 1'b1;
    byteData  = b;
    @(negedge clk);
    byteValid = 1'b0;
    for (int i = 0; i < gap; i++) begin
      byteData = 8'hA5 ^ 8'(i);   // junk while invalid (R9)
      @(negedge clk);
    end
  endtask

  task automatic send(input logic [15:0] h, input logic [31:0] tailWord,
                      input int gap);
    exp_t e;
    e = model(h);
    decQ.push_back(e);
    if (e.tail) immQ.push_back(tailWord);
    putByte(h[15:8], gap);
    putByte(h[7:0], gap);
    if (e.tail)
      for (int k = 3; k >= 0; k--) putByte(tailWord[k*8 +: 8], gap);
  endtask

  // Monitor: results are due right after the accepting edge.
  always @(negedge clk) begin
    if (rstN) begin
      if (decValid) begin
        if (decQ.size() == 0) begin
          chk(1'b0, "R7 unexpected decValid", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = decQ.pop_front();
          lastExp = e;
          chk(form == e.form, "R1 form", 32'(form), 32'(e.form));
          chk(opcode == e.opcode,
              e.form == 2'd1 ? "R2 opcode" : (e.form == 2'd2 ? "R3 opcode" : "R4 opcode"),
              32'(opcode), 32'(e.opcode));
          chk(regA == e.regA && regB == e.regB,
              e.form == 2'd2 ? "R3 regs" : "R2 regs",
              32'({regA, regB}), 32'({e.regA, e.regB}));
          chk(imm8 == e.imm8, "R3 imm8", 32'(imm8), 32'(e.imm8));
          chk(disp == e.disp, "R4 disp", disp, e.disp);
          chk(hasImm == e.tail && instLen == e.len, "R5 length",
              32'({hasImm, instLen}), 32'({e.tail, e.len}));
          chk(illegal == e.ill, "R6 illegal", 32'(illegal), 32'(e.ill));
        end
      end
      if (immValid) begin
        if (immQ.size() == 0) begin
          chk(1'b0, "R8 unexpected immValid", 32'd1, 32'd0);
        end else begin
          logic [31:0] w;
          w = immQ.pop_front();
          chk(immWord == w, "R8 immWord", immWord, w);
        end
      end
    end
  end

  initial begin
    #4_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(decValid == 1'b0 && immValid == 1'b0, "R10 pulses idle",
        32'({decValid, immValid}), 32'd0);
    chk(immWord == 32'd0, "R10 immWord", immWord, 32'd0);

    send(16'h0212, 32'h0, 0);            // R2 plain register form
    send(16'h0130, 32'hDEADBEEF, 0);     // R5 R8 tail opcode
    send(16'h0000, 32'h0, 1);            // R6 opcode 0 illegal
    send(16'h1500, 32'h0, 0);            // R6 gap range illegal
    send(16'h7F44, 32'h0, 2);            // R6 high illegal
    send(16'h0F00, 32'h0, 0);            // R6 top of lower legal range
    send(16'h1967, 32'h0, 0);            // R5 legal, no tail
    send(16'h39AB, 32'h01234567, 3);     // R8 R9 tail with gaps
    send(16'h3000, 32'h89ABCDEF, 0);     // R5 tail
    send(16'h8A7F, 32'h0, 0);            // R3 add-constant
    send(16'hB3FF, 32'h0, 1);            // R3 write special register
    send(16'hC001, 32'h0, 0);            // R4 +2
    send(16'hC3FF, 32'h0, 0);            // R4 -2
    send(16'hE600, 32'h0, 0);            // R4 code 9, -1024
    send(16'hE800, 32'h0, 0);            // R6 branch code 0xA illegal
    send(16'h1D00, 32'hFFFF0001, 0);     // R8 back-to-back tail
    send(16'h0C21, 32'h00000080, 0);     // R8
    send(16'h0E21, 32'h0, 0);            // R2 after tail: new high byte

    // R7 and R9: fields hold across idle cycles with junk on byteData
    repeat (4) begin
      byteData = 8'hFF;
      @(negedge clk);
    end
    chk(opcode == lastExp.opcode && form == lastExp.form, "R7 hold",
        32'({form, opcode}), 32'({lastExp.form, lastExp.opcode}));
    chk(decValid == 1'b0 && immValid == 1'b0, "R9 idle no pulse",
        32'({decValid, immValid}), 32'd0);
    chk(decQ.size() == 0, "R7 all decoded", 32'(decQ.size()), 32'd0);
    chk(immQ.size() == 0, "R8 all words", 32'(immQ.size()), 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule